// File: doc/BRIEF.md
# ROM Boot Copy Controller

This block starts the chip after reset. On the first clock edge after reset is released it samples a pair of mode straps and an endianness strap. It then either copies a fixed 1 KB image from the base of an external ROM window into on-chip memory, starting at word 0, or waits for a host to finish loading. The processor core stays held until one of these two paths ends. After that the core is released to fetch from address 0.

The ROM can be 8, 16 or 32 bits wide. For narrow ROMs the controller issues one read per beat and gathers the beats into full 32-bit words before writing each word. The order in which beats fill a word follows the endianness strap. Both the ROM read port and the memory write port use a request/acknowledge handshake with one transfer outstanding.

Top module: `rom_boot_ctrl`

## Requirements
- R1: Reset `rst_n` is asynchronous and active low. On the first rising clock edge with `rst_n` high, `strap_mode` and `strap_le` are captured. Later changes to them have no effect until the next reset. No ROM read is issued before the capture.
- R2: `strap_mode` selects the boot path: 2'b00 = host wait, 2'b01 = 8-bit ROM, 2'b10 = 16-bit ROM, 2'b11 = 32-bit ROM. A ROM beat is taken from `rom_rdata[7:0]`, `rom_rdata[15:0]` or `rom_rdata[31:0]` according to the width, and the unused upper bits are ignored. A copy issues 1024/(width/8) reads.
- R3: ROM byte addresses start at 0 and rise by width/8 per beat, so every read address is aligned to the beat width.
- R4: `rom_req` stays high with `rom_addr` stable until `rom_ack`, and the data is taken in the `rom_ack` cycle. `mem_we` stays high with `mem_addr` and `mem_wdata` stable until `mem_ack`.
- R5: With `strap_le`=1, the beat from the lowest ROM address fills bits [7:0] in 8-bit mode and bits [15:0] in 16-bit mode. Each later beat fills the next higher lane.
- R6: With `strap_le`=0, the beat from the lowest ROM address fills bits [31:24] in 8-bit mode and bits [31:16] in 16-bit mode. Each later beat fills the next lower lane. In 32-bit mode the ROM word is written unchanged for either strap value.
- R7: Exactly 256 words are written, to word addresses 0 to 255 in ascending order. `rom_req` and `mem_we` are never high together.
- R8: `core_release` and `boot_done` stay low until the write to word 255 is acknowledged. Both go high in the following cycle and remain high.
- R9: In host-wait mode no ROM read and no memory write occur. `core_release` rises in the cycle after `host_go` is sampled high, and `boot_done` stays low. In ROM modes `host_go` is ignored.
- R10: While `rst_n` is low, `rom_req`, `mem_we`, `core_release` and `boot_done` are low. A reset during a copy discards it, and the next copy starts again from address 0.
- R11: Once `core_release` is high, no further ROM read or memory write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_mode | input | 2 | Boot path and ROM width strap |
| strap_le | input | 1 | Byte-order strap, 1 = little endian |
| host_go | input | 1 | Host signals that its load is complete (host-wait mode) |
| rom_req | output | 1 | ROM read request |
| rom_addr | output | ROM_AW | ROM byte address within the window |
| rom_rdata | input | 32 | ROM read data, low-justified |
| rom_ack | input | 1 | ROM read acknowledge, data valid |
| mem_we | output | 1 | On-chip memory write request |
| mem_addr | output | WORD_AW | On-chip word address |
| mem_wdata | output | 32 | Assembled word |
| mem_ack | input | 1 | Memory write acknowledge |
| core_release | output | 1 | Core may start fetching at address 0 |
| boot_done | output | 1 | ROM copy completed |

## Verification
The bound assertions check the rules that hold on every cycle:
- handshake holding;
- exclusion between the two ports;
- address alignment for each width;
- stickiness of release and done;
- silence after release and in host-wait mode;
- that release rises only after a final write acknowledge or a host go.

Whether each word holds the right bytes in the right lanes for every width and byte order can only be shown by the bench's full copies against its own image model. The same holds for ignoring strap changes after capture, restarting after a reset in the middle of a copy, and the exact release cycle.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [1:0] {
    BM_HOST  = 2'b00,
    BM_ROM8  = 2'b01,
    BM_ROM16 = 2'b10,
    BM_ROM32 = 2'b11
  } boot_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_STORE,
    ST_HOLD,
    ST_RUN
  } boot_state_e;

  // bytes delivered by one ROM beat
  function automatic int beat_bytes(input boot_mode_e mode);
    case (mode)
      BM_ROM8:  return 1;
      BM_ROM16: return 2;
      default:  return 4;
    endcase
  endfunction

  // place one beat into the word under assembly; off is the byte offset
  // of the beat inside its word
  function automatic logic [31:0] merge_beat(input logic [31:0] acc,
                                             input logic [31:0] data,
                                             input boot_mode_e  mode,
                                             input logic        le,
                                             input logic [1:0]  off);
    logic [31:0] r;
    int bpb, slot, nslots, pos;
    r      = acc;
    bpb    = beat_bytes(mode);
    slot   = int'(off) / bpb;
    nslots = 4 / bpb;
    pos    = le ? slot : (nslots - 1 - slot);
    for (int b = 0; b < 4; b++) begin
      if (b < bpb) r[(pos*bpb + b)*8 +: 8] = data[b*8 +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
  import boot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_mode_i,
  input  logic       strap_le_i,
  output boot_mode_e mode_o,
  output logic       le_o,
  output logic       captured_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o     <= BM_ROM8;
      le_o       <= 1'b1;
      captured_o <= 1'b0;
    end else if (!captured_o) begin
      mode_o     <= boot_mode_e'(strap_mode_i);
      le_o       <= strap_le_i;
      captured_o <= 1'b1;
    end
  end

endmodule

// File: rtl/boot_fetch_seq.sv
module boot_fetch_seq
  import boot_pkg::*;
#(
  parameter int IMAGE_BYTES = 1024,
  parameter int ROM_AW      = 17,
  localparam int PTR_W      = $clog2(IMAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_fire,
  input  boot_mode_e        mode,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [1:0]        beat_off,
  output logic              word_full
);

  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] step;

  assign step = PTR_W'(beat_bytes(mode));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr <= '0;
    else if (beat_fire) ptr <= ptr + step;
  end

  assign rom_addr  = ROM_AW'(ptr);
  assign beat_off  = ptr[1:0];
  // this beat completes a word when it occupies the last slot
  assign word_full = (3'(ptr[1:0]) + 3'(step)) == 3'd4;

endmodule

// File: rtl/boot_word_packer.sv
module boot_word_packer
  import boot_pkg::*;
#(
  parameter int IMAGE_BYTES = 1024,
  localparam int WORD_AW    = $clog2(IMAGE_BYTES/4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat_fire,
  input  logic [31:0]        beat_data,
  input  logic [1:0]         beat_off,
  input  boot_mode_e         mode,
  input  logic               le,
  input  logic               store_fire,
  output logic [31:0]        word,
  output logic [WORD_AW-1:0] word_idx,
  output logic               last_word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         word <= '0;
    else if (beat_fire) word <= merge_beat(word, beat_data, mode, le, beat_off);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          word_idx <= '0;
    else if (store_fire) word_idx <= word_idx + 1'b1;
  end

  assign last_word = &word_idx;

endmodule

// File: rtl/rom_boot_ctrl.sv
module rom_boot_ctrl
  import boot_pkg::*;
#(
  parameter int IMAGE_BYTES = 1024,
  parameter int ROM_AW      = 17,
  localparam int WORD_AW    = $clog2(IMAGE_BYTES/4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         strap_mode,
  input  logic               strap_le,
  input  logic               host_go,
  output logic               rom_req,
  output logic [ROM_AW-1:0]  rom_addr,
  input  logic [31:0]        rom_rdata,
  input  logic               rom_ack,
  output logic               mem_we,
  output logic [WORD_AW-1:0] mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic               mem_ack,
  output logic               core_release,
  output logic               boot_done
);

  boot_state_e state;
  boot_mode_e  lat_mode;
  logic        lat_le;
  logic        captured;
  logic [1:0]  beat_off;
  logic        word_full;
  logic        last_word;
  logic        done_q;

  // named events used by the FSM and the checker
  logic ev_beat, ev_store, ev_final, ev_go;
  assign ev_beat  = rom_req & rom_ack;
  assign ev_store = mem_we & mem_ack;
  assign ev_final = ev_store & last_word;
  assign ev_go    = (state == ST_HOLD) & host_go;

  boot_strap_latch u_straps (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_mode_i (strap_mode),
    .strap_le_i   (strap_le),
    .mode_o       (lat_mode),
    .le_o         (lat_le),
    .captured_o   (captured)
  );

  boot_fetch_seq #(.IMAGE_BYTES(IMAGE_BYTES), .ROM_AW(ROM_AW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_fire (ev_beat),
    .mode      (lat_mode),
    .rom_addr  (rom_addr),
    .beat_off  (beat_off),
    .word_full (word_full)
  );

  boot_word_packer #(.IMAGE_BYTES(IMAGE_BYTES)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_fire  (ev_beat),
    .beat_data  (rom_rdata),
    .beat_off   (beat_off),
    .mode       (lat_mode),
    .le         (lat_le),
    .store_fire (ev_store),
    .word       (mem_wdata),
    .word_idx   (mem_addr),
    .last_word  (last_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (captured) state <= (lat_mode == BM_HOST) ? ST_HOLD : ST_FETCH;
        ST_FETCH: if (ev_beat && word_full) state <= ST_STORE;
        ST_STORE: if (ev_store) state <= last_word ? ST_RUN : ST_FETCH;
        ST_HOLD:  if (ev_go) state <= ST_RUN;
        ST_RUN:   state <= ST_RUN;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (ev_final) done_q <= 1'b1;
  end

  assign rom_req      = (state == ST_FETCH);
  assign mem_we       = (state == ST_STORE);
  assign core_release = (state == ST_RUN);
  assign boot_done    = done_q;

endmodule

// File: rtl/boot_ctrl_checker.sv
module boot_ctrl_checker #(
  parameter int ROM_AW  = 17,
  parameter int WORD_AW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rom_req,
  input logic               rom_ack,
  input logic [ROM_AW-1:0]  rom_addr,
  input logic               mem_we,
  input logic               mem_ack,
  input logic [WORD_AW-1:0] mem_addr,
  input logic [31:0]        mem_wdata,
  input logic               core_release,
  input logic               boot_done,
  input logic               ev_final,
  input logic               ev_go,
  input logic [1:0]         lat_mode,
  input logic               captured
);

  AST_NO_READ_BEFORE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !captured |-> !rom_req); // R1
  AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    captured && $past(captured) |-> $stable(lat_mode)); // R1
  AST_ALIGN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req && lat_mode == 2'b10 |-> !rom_addr[0]); // R3
  AST_ALIGN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req && lat_mode == 2'b11 |-> rom_addr[1:0] == 2'b00); // R3
  AST_ROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req && !rom_ack |=> rom_req && $stable(rom_addr)); // R4
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !mem_ack |=> mem_we && $stable(mem_addr) && $stable(mem_wdata)); // R4
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_req && mem_we)); // R7
  AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_release) |-> $past(ev_final || ev_go)); // R8
  AST_RELEASE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    core_release |=> core_release); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done); // R8
  AST_HOST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    captured && lat_mode == 2'b00 |-> !rom_req && !mem_we && !boot_done); // R9
  AST_QUIET_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    core_release |-> !rom_req && !mem_we); // R11

endmodule

bind rom_boot_ctrl boot_ctrl_checker #(.ROM_AW(ROM_AW), .WORD_AW(WORD_AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rom_req      (rom_req),
  .rom_ack      (rom_ack),
  .rom_addr     (rom_addr),
  .mem_we       (mem_we),
  .mem_ack      (mem_ack),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .core_release (core_release),
  .boot_done    (boot_done),
  .ev_final     (ev_final),
  .ev_go        (ev_go),
  .lat_mode     (lat_mode),
  .captured     (captured)
);

// File: tb/tb_rom_boot_ctrl.sv
module tb_rom_boot_ctrl;

  localparam int ROM_AW  = 17;
  localparam int WORD_AW = 8;
  localparam int NWORDS  = 256;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [1:0]         strap_mode = 2'b01;
  logic               strap_le = 1'b1;
  logic               host_go = 1'b0;
  logic               rom_req;
  logic [ROM_AW-1:0]  rom_addr;
  logic [31:0]        rom_rdata = '0;
  logic               rom_ack = 1'b0;
  logic               mem_we;
  logic [WORD_AW-1:0] mem_addr;
  logic [31:0]        mem_wdata;
  logic               mem_ack = 1'b0;
  logic               core_release;
  logic               boot_done;

  always #4 clk = ~clk;

  rom_boot_ctrl dut (
    .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode), .strap_le(strap_le),
    .host_go(host_go), .rom_req(rom_req), .rom_addr(rom_addr),
    .rom_rdata(rom_rdata), .rom_ack(rom_ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .core_release(core_release), .boot_done(boot_done)
  );

  int n_checks = 0;
  int n_bad    = 0;
  int cyc      = 0;

  // state of the current run, used by the responders
  logic [1:0]  cur_mode;
  logic        cur_le;
  logic [31:0] salt;
  int          nreads, nwrites;
  bit          early_release;
  bit          final_pending;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bytes_of(input logic [1:0] m);
    return (m == 2'b01) ? 1 : (m == 2'b10) ? 2 : 4;
  endfunction

  function automatic logic [31:0] romv(input int a);
    return (32'(a) * 32'h9E3779B1) ^ salt;
  endfunction

  function automatic logic [31:0] width_mask(input logic [1:0] m);
    return (m == 2'b01) ? 32'h0000_00FF : (m == 2'b10) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  // expected word i built from the byte-order rules
  function automatic logic [31:0] exp_word(input int i);
    logic [31:0] w = '0;
    logic [15:0] h0, h1;
    case (cur_mode)
      2'b01: for (int k = 0; k < 4; k++) begin
               logic [7:0] v = romv(4*i + k) & 32'hFF;
               if (cur_le) w = w | (32'(v) << (8*k));
               else        w = w | (32'(v) << (8*(3-k)));
             end
      2'b10: begin
               h0 = romv(4*i)[15:0];
               h1 = romv(4*i + 2)[15:0];
               w  = cur_le ? {h1, h0} : {h0, h1};
             end
      default: w = romv(4*i);
    endcase
    return w;
  endfunction

  function automatic string data_tag();
    if (cur_mode == 2'b11) return "R6";
    return cur_le ? "R5" : "R6";
  endfunction

  // ROM responder
  initial begin
    int lat = -1;
    logic [ROM_AW-1:0] held;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        rom_ack = 1'b0; lat = -1;
      end else if (rom_ack) begin
        rom_ack = 1'b0; lat = -1;
      end else if (rom_req) begin
        if (core_release) early_release = 1'b1;
        if (lat < 0) begin
          lat  = int'($urandom % 3);
          held = rom_addr;
        end else begin
          chk(rom_addr == held, "R4", 32'(rom_addr), 32'(held));
        end
        if (lat == 0) begin
          chk(32'(rom_addr) == 32'(nreads * bytes_of(cur_mode)), "R3",
              32'(rom_addr), 32'(nreads * bytes_of(cur_mode)));
          rom_rdata = (romv(int'(rom_addr)) & width_mask(cur_mode)) |
                      ($urandom & ~width_mask(cur_mode));
          rom_ack = 1'b1;
          nreads++;
        end else begin
          lat--;
        end
      end
    end
  end

  // memory responder
  initial begin
    int lat = -1;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_ack = 1'b0; lat = -1; final_pending = 1'b0;
      end else if (mem_ack) begin
        mem_ack = 1'b0; lat = -1;
        if (final_pending) begin
          final_pending = 1'b0;
          chk(core_release && boot_done, "R8", {30'd0, core_release, boot_done}, 32'd3);
        end
      end else if (mem_we) begin
        if (lat < 0) lat = int'($urandom % 3);
        if (lat == 0) begin
          chk(32'(mem_addr) == 32'(nwrites), "R7", 32'(mem_addr), 32'(nwrites));
          chk(mem_wdata == exp_word(nwrites), data_tag(), mem_wdata, exp_word(nwrites));
          if (core_release || boot_done) early_release = 1'b1;
          mem_ack = 1'b1;
          nwrites++;
          if (nwrites == NWORDS) final_pending = 1'b1;
        end else begin
          lat--;
        end
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= 150000) begin
        n_checks++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
      end
    end
  end

  task automatic enter_reset(input logic [1:0] m, input logic le);
    @(negedge clk);
    rst_n = 1'b0;
    strap_mode = m; strap_le = le;
    cur_mode = m; cur_le = le;
    salt = $urandom;
    nreads = 0; nwrites = 0; early_release = 1'b0;
    repeat (2) @(negedge clk);
    chk(!rom_req && !mem_we && !core_release && !boot_done, "R10",
        {28'd0, rom_req, mem_we, core_release, boot_done}, 32'd0);
  endtask

  // full ROM copy; abort_after > 0 resets the block mid-copy instead
  task automatic run_copy(input logic [1:0] m, input logic le, input bit tweak,
                          input int abort_after);
    int t = 0;
    enter_reset(m, le);
    rst_n = 1'b1;
    if (tweak) begin
      repeat (2) @(negedge clk);
      strap_mode = ~m; strap_le = ~le;
    end
    while (!core_release && t < 20000) begin
      @(negedge clk);
      host_go = $urandom_range(0, 1) == 1; // ignored in ROM modes (R9)
      t++;
      if (abort_after > 0 && t == abort_after) begin
        rst_n = 1'b0;
        #1;
        chk(!rom_req && !mem_we && !core_release && !boot_done, "R10",
            {28'd0, rom_req, mem_we, core_release, boot_done}, 32'd0);
        host_go = 1'b0;
        return;
      end
    end
    host_go = 1'b0;
    chk(core_release, "R8", 32'(core_release), 32'd1);
    chk(nreads == 1024 / bytes_of(cur_mode), tweak ? "R1" : "R2",
        32'(nreads), 32'(1024 / bytes_of(cur_mode)));
    chk(nwrites == NWORDS, "R7", 32'(nwrites), 32'(NWORDS));
    chk(!early_release, "R8", 32'(early_release), 32'd0);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!rom_req && !mem_we && core_release && boot_done, "R11",
          {28'd0, rom_req, mem_we, core_release, boot_done}, 32'd3);
    end
  endtask

  task automatic run_host();
    enter_reset(2'b00, 1'b1);
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(!rom_req && !mem_we && !core_release && !boot_done, "R9",
          {28'd0, rom_req, mem_we, core_release, boot_done}, 32'd0);
    end
    host_go = 1'b1;
    @(negedge clk);
    host_go = 1'b0;
    chk(core_release && !boot_done, "R9", {30'd0, core_release, boot_done}, 32'd2);
    chk(nreads == 0 && nwrites == 0, "R9", 32'(nreads + nwrites), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    // directed: every width and byte order
    run_copy(2'b01, 1'b1, 1'b0, 0);
    run_copy(2'b01, 1'b0, 1'b0, 0);
    run_copy(2'b10, 1'b1, 1'b0, 0);
    run_copy(2'b10, 1'b0, 1'b0, 0);
    run_copy(2'b11, 1'b1, 1'b0, 0);
    run_copy(2'b11, 1'b0, 1'b0, 0);
    // straps moved after capture (R1)
    run_copy(2'b01, 1'b1, 1'b1, 0);
    run_copy(2'b10, 1'b0, 1'b1, 0);
    // reset in mid-copy, then a clean restart (R10)
    run_copy(2'b10, 1'b1, 1'b0, 700);
    run_copy(2'b10, 1'b1, 1'b0, 0);
    // host-wait path
    run_host();
    // random configurations
    for (int r = 0; r < 3; r++) begin
      logic [1:0] m = 2'($urandom_range(1, 3));
      run_copy(m, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0);
    end
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule